// File: doc/BRIEF.md
# Scan Chain Shift Controller

This block lets a host processor work on a long serial configuration chain that lives inside one of several lane groups. The host programs a control register with a clock divider exponent, a group number and a per-group bypass mask. It then writes a data register that carries a 32-bit shift buffer, a bit count, a one-hot group select and three command bits. The controller generates a divided test clock. It streams buffer bits out on its serial output and collects the bits that return from the chain. It also drives a one-period load strobe and a one-period store strobe toward the selected group.

Every command bit doubles as a busy flag. It reads back as 1 while its operation runs and clears itself when the operation ends, so the host starts an operation and then polls. Runs longer than 32 bits are built from repeated shift commands. Bits that leave the chain gather at the top of the buffer, and the host recovers them with a right shift of (32 − N).

The sequencer is a four-state machine:
- `ST_IDLE` moves on an accepted data write that has any command bit set. It goes to the first pending operation in the fixed order capture, shift, update.
- `ST_CAPTURE` and `ST_UPDATE` each last one test-clock period. At the end of that period the state clears its own command bit and moves to the next pending operation, or back to `ST_IDLE`.
- `ST_SHIFT` stays for count+1 test-clock periods. At the end of the last period it clears the shift bit and moves to `ST_UPDATE` if an update is pending, otherwise to `ST_IDLE`.

Top module: `scan_chain_ctrl`

## Requirements
- R1: After reset both registers read as zero, the test clock is low and no strobe or shift enable is asserted.
- R2: While an operation runs, the test clock has a period of 2^(div+2) system clocks. It is low for the first half of each period and high for the second half. It is low whenever no command bit is set, and every operation ends with the clock falling.
- R3: A shift command moves count+1 bits, from 1 to 32, and each bit takes exactly one test-clock period.
- R4: Buffer bit 0 is sent first. Serial input to the chain changes only at the start of an operation or when the test clock falls, and the returning bit is sampled when it rises. After an N-bit shift the chain's N most significant positions hold the data, with bit N−1 at the top.
- R5: After an N-bit shift, the buffer holds the N returned bits in positions 31 down to 32−N, with the first returned bit lowest. The untransmitted data bits sit below them, moved down by N.
- R6: The command bits (shift at data bit 40, update at 41, capture at 42) read as 1 from the accepted write until their own operation completes. When several are set they run capture, then shift, then update, and only one kind of activity is driven at a time.
- R7: Capture and update each drive a strobe lasting exactly one test-clock period that begins with the test clock low. The strobe goes only to groups whose select bit (data bits 51:48) is set.
- R8: Shift enable goes only to groups that are both selected and have their bypass bit set. The returning serial bit is taken from the group named by the group field, and other groups' chains are not disturbed.
- R9: When the addressed group's bypass bit is clear, its chain is replaced by a one-bit internal register. The returned stream is then the previous last-sent bit followed by the sent data, delayed by one.
- R10: Writes to either register are ignored while any command bit is set. Reads are accepted at any time.
- R11: Register map. Address 0 holds the divider exponent in bits 2:0, the group field in bits 9:8 and the bypass mask in bits 19:16. Address 1 holds the buffer in bits 31:0, the count in bits 36:32, the command bits at 40–42 and the select mask in bits 51:48. Every field reads back as written, and all other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 control, 1 data |
| wr_data | input | 64 | Write value |
| rd_addr | input | 1 | Read target: 0 control, 1 data |
| rd_data | output | 64 | Read value of the addressed register |
| tck_o | output | 1 | Divided test clock |
| tdi_o | output | 1 | Serial data toward the chain |
| tdo_i | input | NGRP | Serial return from each group's chain |
| shift_en_o | output | NGRP | Per-group shift enable |
| upd_o | output | NGRP | Per-group update strobe |
| cap_o | output | NGRP | Per-group capture strobe |

## Verification
The assertions assume the host keeps the group field consistent with the one-hot select it writes. They also assume the number of groups is a power of two, so the group field never indexes past the return vector. The stimulus meets both assumptions: it always writes a select of 1 shifted by the programmed group, and it uses the default of four groups. The checks on tck phase and end of operation rely on the divider staying fixed during a command. The design guarantees this by refusing control writes while busy, and the stimulus deliberately attempts such writes mid-operation to exercise that refusal.

// File: rtl/scan_chain_pkg.sv
package scan_chain_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_SHIFT   = 2'd2,
        ST_UPDATE  = 2'd3
    } scan_state_e;

    localparam int REG_W = 64;

    // control register fields
    localparam int CTL_DIV_LSB = 0;
    localparam int CTL_GRP_LSB = 8;
    localparam int CTL_BYP_LSB = 16;

    // data register fields
    localparam int DAT_CNT_LSB  = 32;
    localparam int DAT_GO_SHIFT = 40;
    localparam int DAT_GO_UPD   = 41;
    localparam int DAT_GO_CAP   = 42;
    localparam int DAT_SEL_LSB  = 48;

endpackage

// File: rtl/scan_chain_tckgen.sv
module scan_chain_tckgen #(
    parameter int DIVW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tck,
    output logic            rise,
    output logic            wrap
);
    localparam int PHW = (1 << DIVW) + 1;

    logic [PHW-1:0] ph;
    logic [PHW-1:0] ph_n;
    logic [PHW-1:0] mask;
    logic [PHW-1:0] half;

    always_comb begin
        mask = (PHW'(1) << (int'(div) + 2)) - PHW'(1);
        half = PHW'(1) << (int'(div) + 1);
        ph_n = (ph + PHW'(1)) & mask;
        rise = run && (ph_n == half);
        wrap = run && (ph_n == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph  <= '0;
            tck <= 1'b0;
        end else if (run) begin
            ph  <= ph_n;
            tck <= (ph_n >= half);
        end else begin
            ph  <= '0;
            tck <= 1'b0;
        end
    end

endmodule

// File: rtl/scan_chain_fsm.sv
module scan_chain_fsm
    import scan_chain_pkg::*;
#(
    parameter int CNTW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            req_shift,
    input  logic            req_upd,
    input  logic            req_cap,
    input  logic [CNTW-1:0] cnt_in,
    input  logic            wrap,
    output logic            go_shift,
    output logic            go_upd,
    output logic            go_cap,
    output logic            busy,
    output logic            run,
    output logic            shifting,
    output logic            updating,
    output logic            capturing
);
    scan_state_e     state, state_n;
    logic            gs_n, gu_n, gc_n;
    logic [CNTW-1:0] left, left_n;

    function automatic scan_state_e pick(input logic c, input logic s, input logic u);
        if (c) return ST_CAPTURE;
        if (s) return ST_SHIFT;
        if (u) return ST_UPDATE;
        return ST_IDLE;
    endfunction

    always_comb begin
        state_n = state;
        gs_n    = go_shift;
        gu_n    = go_upd;
        gc_n    = go_cap;
        left_n  = left;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    gs_n    = req_shift;
                    gu_n    = req_upd;
                    gc_n    = req_cap;
                    left_n  = cnt_in;
                    state_n = pick(req_cap, req_shift, req_upd);
                end
            end
            ST_CAPTURE: begin
                if (wrap) begin
                    gc_n    = 1'b0;
                    state_n = pick(1'b0, go_shift, go_upd);
                end
            end
            ST_SHIFT: begin
                if (wrap) begin
                    if (left == '0) begin
                        gs_n    = 1'b0;
                        state_n = pick(1'b0, 1'b0, go_upd);
                    end else begin
                        left_n = left - CNTW'(1);
                    end
                end
            end
            ST_UPDATE: begin
                if (wrap) begin
                    gu_n    = 1'b0;
                    state_n = ST_IDLE;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            go_shift <= 1'b0;
            go_upd   <= 1'b0;
            go_cap   <= 1'b0;
            left     <= '0;
        end else begin
            state    <= state_n;
            go_shift <= gs_n;
            go_upd   <= gu_n;
            go_cap   <= gc_n;
            left     <= left_n;
        end
    end

    // outputs
    always_comb begin
        busy      = go_shift | go_upd | go_cap;
        run       = (state != ST_IDLE);
        shifting  = (state == ST_SHIFT);
        updating  = (state == ST_UPDATE);
        capturing = (state == ST_CAPTURE);
    end

endmodule

// File: rtl/scan_chain_shifter.sv
module scan_chain_shifter #(
    parameter int BUFW = 32,
    parameter int NGRP = 4,
    parameter int GW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BUFW-1:0] load_val,
    input  logic            shifting,
    input  logic            rise,
    input  logic            wrap,
    input  logic [NGRP-1:0] tdo_i,
    input  logic [GW-1:0]   grp,
    input  logic [NGRP-1:0] byp_mask,
    output logic [BUFW-1:0] buf_q,
    output logic            tdi
);
    logic samp;
    logic byp_bit;
    logic ret;

    assign ret = byp_mask[grp] ? tdo_i[grp] : byp_bit;
    assign tdi = shifting & buf_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q   <= '0;
            samp    <= 1'b0;
            byp_bit <= 1'b0;
        end else begin
            if (load) begin
                buf_q <= load_val;
            end else if (shifting && wrap) begin
                buf_q <= {samp, buf_q[BUFW-1:1]};
            end
            if (shifting && rise) begin
                samp <= ret;
                if (!byp_mask[grp]) begin
                    byp_bit <= tdi;
                end
            end
        end
    end

endmodule

// File: rtl/scan_chain_ctrl.sv
module scan_chain_ctrl
    import scan_chain_pkg::*;
#(
    parameter int NGRP = 4,
    parameter int DIVW = 3,
    parameter int BUFW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic             tck_o,
    output logic             tdi_o,
    input  logic [NGRP-1:0]  tdo_i,
    output logic [NGRP-1:0]  shift_en_o,
    output logic [NGRP-1:0]  upd_o,
    output logic [NGRP-1:0]  cap_o
);
    localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1;
    localparam int CNTW = (BUFW > 1) ? $clog2(BUFW) : 1;

    logic [DIVW-1:0] div_q;
    logic [GW-1:0]   grp_q;
    logic [NGRP-1:0] bmask_q;
    logic [NGRP-1:0] sel_q;
    logic [CNTW-1:0] cnt_q;
    logic [BUFW-1:0] buf_q;

    logic go_shift, go_upd, go_cap, busy, run;
    logic shifting, updating, capturing;
    logic rise, wrap;
    logic wr_ctl, wr_dat, start;
    logic unused_wr;

    assign wr_ctl = wr_en && !wr_addr && !busy;
    assign wr_dat = wr_en &&  wr_addr && !busy;
    assign start  = wr_dat && (wr_data[DAT_GO_SHIFT] || wr_data[DAT_GO_UPD] || wr_data[DAT_GO_CAP]);
    assign unused_wr = ^wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            grp_q   <= '0;
            bmask_q <= '0;
            sel_q   <= '0;
            cnt_q   <= '0;
        end else begin
            if (wr_ctl) begin
                div_q   <= wr_data[CTL_DIV_LSB +: DIVW];
                grp_q   <= wr_data[CTL_GRP_LSB +: GW];
                bmask_q <= wr_data[CTL_BYP_LSB +: NGRP];
            end
            if (wr_dat) begin
                sel_q <= wr_data[DAT_SEL_LSB +: NGRP];
                cnt_q <= wr_data[DAT_CNT_LSB +: CNTW];
            end
        end
    end

    scan_chain_tckgen #(.DIVW(DIVW)) u_tck (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .div  (div_q),
        .tck  (tck_o),
        .rise (rise),
        .wrap (wrap)
    );

    scan_chain_fsm #(.CNTW(CNTW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .req_shift(wr_data[DAT_GO_SHIFT]),
        .req_upd  (wr_data[DAT_GO_UPD]),
        .req_cap  (wr_data[DAT_GO_CAP]),
        .cnt_in   (wr_data[DAT_CNT_LSB +: CNTW]),
        .wrap     (wrap),
        .go_shift (go_shift),
        .go_upd   (go_upd),
        .go_cap   (go_cap),
        .busy     (busy),
        .run      (run),
        .shifting (shifting),
        .updating (updating),
        .capturing(capturing)
    );

    scan_chain_shifter #(.BUFW(BUFW), .NGRP(NGRP), .GW(GW)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wr_dat),
        .load_val(wr_data[BUFW-1:0]),
        .shifting(shifting),
        .rise    (rise),
        .wrap    (wrap),
        .tdo_i   (tdo_i),
        .grp     (grp_q),
        .byp_mask(bmask_q),
        .buf_q   (buf_q),
        .tdi     (tdi_o)
    );

    assign shift_en_o = {NGRP{shifting}}  & sel_q & bmask_q;
    assign upd_o      = {NGRP{updating}}  & sel_q;
    assign cap_o      = {NGRP{capturing}} & sel_q;

    always_comb begin
        rd_data = '0;
        if (rd_addr) begin
            rd_data[BUFW-1:0]              = buf_q;
            rd_data[DAT_CNT_LSB +: CNTW]   = cnt_q;
            rd_data[DAT_GO_SHIFT]          = go_shift;
            rd_data[DAT_GO_UPD]            = go_upd;
            rd_data[DAT_GO_CAP]            = go_cap;
            rd_data[DAT_SEL_LSB +: NGRP]   = sel_q;
        end else begin
            rd_data[CTL_DIV_LSB +: DIVW]   = div_q;
            rd_data[CTL_GRP_LSB +: GW]     = grp_q;
            rd_data[CTL_BYP_LSB +: NGRP]   = bmask_q;
        end
    end

endmodule

// File: rtl/scan_chain_ctrl_chk.sv
module scan_chain_ctrl_chk #(
    parameter int NGRP = 4,
    parameter int DIVW = 3,
    parameter int GW   = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            wr_addr,
    input logic            tck_o,
    input logic            tdi_o,
    input logic            busy,
    input logic [NGRP-1:0] shift_en_o,
    input logic [NGRP-1:0] upd_o,
    input logic [NGRP-1:0] cap_o,
    input logic [NGRP-1:0] sel_q,
    input logic [NGRP-1:0] bmask_q,
    input logic [DIVW-1:0] div_q,
    input logic [GW-1:0]   grp_q
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tck_o && shift_en_o == '0 && upd_o == '0 && cap_o == '0)); // R2

    AST_END_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!tck_o && $past(tck_o))); // R2

    AST_TDI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tck_o && $past(tck_o)) |-> $stable(tdi_o)); // R4

    AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({|shift_en_o, |upd_o, |cap_o})); // R6

    AST_STROBE_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(|upd_o) || $rose(|cap_o)) |-> !tck_o); // R7

    AST_STROBE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        ((upd_o | cap_o) & ~sel_q) == '0); // R7

    AST_SHIFT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en_o & ~bmask_q) == '0); // R8

    AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && !wr_addr) |=> ($stable(div_q) && $stable(grp_q) && $stable(bmask_q))); // R10

endmodule

bind scan_chain_ctrl scan_chain_ctrl_chk #(.NGRP(NGRP), .DIVW(DIVW), .GW(GW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .tck_o     (tck_o),
    .tdi_o     (tdi_o),
    .busy      (busy),
    .shift_en_o(shift_en_o),
    .upd_o     (upd_o),
    .cap_o     (cap_o),
    .sel_q     (sel_q),
    .bmask_q   (bmask_q),
    .div_q     (div_q),
    .grp_q     (grp_q)
);

// File: tb/sim_scan_chain_ctrl.sv
module sim_scan_chain_ctrl;
    localparam int NGRP = 4;
    localparam int DIVW = 3;
    localparam int BUFW = 32;
    localparam int CLEN = 40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en, wr_addr, rd_addr;
    logic [63:0]     wr_data, rd_data;
    logic            tck_o, tdi_o;
    logic [NGRP-1:0] tdo_i, shift_en_o, upd_o, cap_o;

    int n_chk = 0;
    int n_bad = 0;

    int       cur_div = 0;
    int       cur_grp = 0;
    bit [3:0] cur_bm  = 4'h0;
    bit       bypbit  = 1'b0;

    logic [CLEN-1:0] chain [NGRP] = '{default: '0};
    logic [CLEN-1:0] cfgm  [NGRP] = '{default: '0};
    logic [CLEN-1:0] lanes [NGRP];

    always #2 clk = ~clk;

    scan_chain_ctrl #(.NGRP(NGRP), .DIVW(DIVW), .BUFW(BUFW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tck_o(tck_o), .tdi_o(tdi_o), .tdo_i(tdo_i),
        .shift_en_o(shift_en_o), .upd_o(upd_o), .cap_o(cap_o)
    );

    // behavioural chains: shift, load from lanes, store to configuration
    always @(posedge tck_o) begin
        for (int g = 0; g < NGRP; g++) begin
            if (shift_en_o[g]) chain[g] <= {tdi_o, chain[g][CLEN-1:1]};
            if (cap_o[g])      chain[g] <= lanes[g];
            if (upd_o[g])      cfgm[g]  <= chain[g];
        end
    end

    always_comb for (int g = 0; g < NGRP; g++) tdo_i[g] = chain[g][0];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_ctrl(input int dv, input int g, input bit [3:0] bm);
        logic [63:0] v;
        v = 64'(dv) | (64'(g) << 8) | (64'(bm) << 16);
        wr(1'b0, v);
        cur_div = dv; cur_grp = g; cur_bm = bm;
        rd_addr = 1'b0; #1;
        chk("R11 control readback", rd_data, v);
        rd_addr = 1'b1;
    endtask

    task automatic do_cmd(input bit cap, input bit sh, input bit up, input int n,
                          input logic [31:0] d, input int g, input bit intrude);
        int P, T, ec_cap, ec_sh, ec_up, act, og;
        int opq[$];
        logic [63:0] f, dm;
        logic [31:0] ob, expbuf;
        logic [CLEN-1:0] pre, post, other;
        logic [NGRP-1:0] sel, esh;
        bit etck, byp;
        P = 1 << (cur_div + 2);
        sel = NGRP'(1) << g;
        byp = !cur_bm[g];
        og = (g + 1) % NGRP;
        other = chain[og];
        if (cap) opq.push_back(1);
        if (sh) repeat (n) opq.push_back(2);
        if (up) opq.push_back(3);
        T = opq.size() * P;
        ec_cap = 0; ec_sh = 0; ec_up = 0;
        for (int i = 0; i < opq.size(); i++) begin
            if (opq[i] == 1) ec_cap = (i + 1) * P;
            if (opq[i] == 2) ec_sh  = (i + 1) * P;
            if (opq[i] == 3) ec_up  = (i + 1) * P;
        end
        pre = cap ? lanes[g] : chain[g];
        f = 64'(d) | (64'(n - 1) << 32) | (64'(sh) << 40) | (64'(up) << 41)
          | (64'(cap) << 42) | (64'(sel) << 48);
        wr(1'b1, f);
        for (int j = 0; j <= T; j++) begin
            if (j > 0) @(negedge clk);
            wr_en = 1'b0;
            act  = (j < T) ? opq[j / P] : 0;
            etck = (j < T) && ((j % P) >= (P / 2));
            esh  = (act == 2 && !byp) ? sel : '0;
            chk("R2 test clock", 64'(tck_o), 64'(etck));
            chk("R7 update strobe", 64'(upd_o), (act == 3) ? 64'(sel) : 64'd0);
            chk("R7 capture strobe", 64'(cap_o), (act == 1) ? 64'(sel) : 64'd0);
            chk("R8 shift enable", 64'(shift_en_o), 64'(esh));
            chk("R6 command bits", 64'(rd_data[42:40]),
                {61'd0, cap && (j < ec_cap), up && (j < ec_up), sh && (j < ec_sh)});
            if (intrude && j == 1) begin wr_en = 1'b1; wr_addr = 1'b1; wr_data = ~f; end
            if (intrude && j == 3) begin wr_en = 1'b1; wr_addr = 1'b0; wr_data = 64'h0003_0107; end
        end
        // expected results
        ob = '0; post = pre;
        if (sh) begin
            if (byp) begin
                for (int j = 0; j < n; j++) ob[j] = (j == 0) ? bypbit : d[j - 1];
                bypbit = d[n - 1];
            end else begin
                for (int j = 0; j < n; j++) ob[j] = pre[j];
                dm = 64'(d) & ((64'd1 << n) - 64'd1);
                post = (pre >> n) | CLEN'(dm << (CLEN - n));
            end
            expbuf = (n == 32) ? ob : ((d >> n) | (ob << (32 - n)));
        end else begin
            expbuf = d;
        end
        #1;
        chk(byp ? "R9 bypass return in buffer" : "R5 returned bits in buffer", 64'(rd_data[31:0]), 64'(expbuf));
        chk("R3 count readback", 64'(rd_data[36:32]), 64'(n - 1));
        chk("R4 chain contents", 64'(chain[g]), 64'(post));
        chk("R8 other group untouched", 64'(chain[og]), 64'(other));
        if (up) chk("R7 update stored chain", 64'(cfgm[g]), 64'(post));
        if (intrude) begin
            rd_addr = 1'b0; #1;
            chk("R10 control write ignored", rd_data,
                64'(cur_div) | (64'(cur_grp) << 8) | (64'(cur_bm) << 16));
            rd_addr = 1'b1;
        end
    endtask

    initial begin
        wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0; rd_addr = 1'b1;
        lanes[0] = 40'h12_3456_789A;
        lanes[1] = 40'hF0_0F0F_F00F;
        lanes[2] = 40'hA5_5A3C_C396;
        lanes[3] = 40'h01_8004_2011;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 data register reset", rd_data, 64'd0);
        rd_addr = 1'b0; #1;
        chk("R1 control register reset", rd_data, 64'd0);
        rd_addr = 1'b1;
        chk("R1 outputs idle", {60'd0, tck_o, |shift_en_o, |upd_o, |cap_o}, 64'd0);
        rst_n = 1'b1;

        set_ctrl(0, 1, 4'hF);
        do_cmd(0, 1, 0, 8,  32'h0000_00A5, 1, 0);
        do_cmd(0, 1, 0, 32, 32'hDEAD_BEEF, 1, 0);   // R3 largest count
        do_cmd(0, 1, 0, 1,  32'h0000_0001, 1, 0);   // R3 smallest count

        set_ctrl(2, 2, 4'hF);
        do_cmd(1, 1, 1, 12, 32'h0000_0C3A, 2, 1);   // R6 ordering, R10 ignored writes

        set_ctrl(1, 3, 4'h7);                        // R9 group 3 bypassed
        do_cmd(0, 1, 0, 5, 32'h0000_0015, 3, 0);
        do_cmd(0, 1, 0, 5, 32'h0000_000A, 3, 0);
        do_cmd(1, 0, 1, 1, 32'h0000_0000, 3, 0);     // R7 strobes still reach bypassed group

        set_ctrl(0, 0, 4'hF);
        do_cmd(0, 0, 1, 1, 32'h0000_0000, 0, 0);
        do_cmd(1, 0, 0, 1, 32'h1234_5678, 0, 0);
        do_cmd(0, 1, 0, 32, 32'h0000_0000, 0, 0);    // R4 long run in two pieces
        do_cmd(0, 1, 0, 8,  32'h0000_0000, 0, 0);
        chk("R4 chain flushed by repeated shifts", 64'(chain[0]), 64'd0);

        set_ctrl(7, 1, 4'hF);                        // R2 largest divider
        do_cmd(0, 1, 0, 2, 32'h0000_0002, 1, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule